// File: doc/BRIEF.md
# MDIO Management Master with Command Register

This block is a management-bus master driven by one 32-bit command and status word. Software first writes the frame fields with the top bit clear, then writes the same word again with the top bit set. The second write launches one frame on the management clock and data lines. The block divides the system clock down to produce the management clock. It drives the data line for the parts of the frame it owns and releases it where the responder answers. When the frame is over it clears the top bit. For a read frame it also leaves the returned 16 bits in the low half of the same word.

A single serial engine runs every frame kind. Two frame families are supported. The classic one uses start code 01 with register reads and writes. The extended one uses start code 00 with address, write and read frames. The opcode alone decides whether the engine drives the data half of the frame or listens to it. Every frame is 32 preamble ones, then the start code, opcode, port address, register or device address, a 2-bit turnaround and 16 data bits.

Top module: `mdio_cmd_ctrl`

## Requirements
- R1: The command word holds data in bits 15:0, start code in 17:16, opcode in 19:18, port address in 24:20, register/device address in 29:25 and go/busy in bit 31. Bit 30 always reads 0. A write accepted while idle reads back unchanged in bits 29:0.
- R2: Writing bit 31 as 1 while idle starts a frame. Bit 31 reads 1 for exactly 128*DIV_HALF system clock cycles, counted from the accepting clock edge, and is then cleared by hardware.
- R3: A write with bit 31 at 0 only stores the fields. Bit 31 stays 0 and the management clock does not toggle.
- R4: The management clock idles low. It toggles every DIV_HALF system clock cycles while a frame runs and gives exactly PRE_LEN+32 rising edges per frame.
- R5: At each rising edge of the management clock the line carries the frame bits in this order: PRE_LEN ones, start code, opcode, port address, register address, turnaround, data. Every field is sent MSB first. For a frame whose opcode bit 1 is 0, the block drives the turnaround as 1 then 0 and then the data field. It changes the line only on falling management clock edges.
- R6: A frame whose opcode bit 1 is 1 is a read (start 01 with opcode 10, or start 00 with opcode 11). The block releases the line from the first turnaround bit to the end of the frame. It samples the 16 responder bits on rising clock edges and, at frame end, places them in bits 15:0 of the word, MSB first.
- R7: An extended address frame (start 00, opcode 00) is sent exactly like a write. Its 16-bit data field goes on the line as the register address for the device.
- R8: A write to the command word while bit 31 reads 1 is ignored. Neither the fields nor the frame in progress change, and no second frame starts.
- R9: After reset the word reads 0. While idle the line is released and the management clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Write strobe for the command word |
| reg_wr_data | input | 32 | Value written to the command word |
| reg_rd_data | output | 32 | Current command/status word |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line value when driven |
| mdio_oe | output | 1 | Data line drive enable |
| mdio_i | input | 1 | Data line as seen on the pin |

## Verification
The bench sweeps all five frame kinds across port and register addresses at both range ends and in the middle. Each frame uses a data or response word derived from those addresses, so a misplaced or swapped field shows up as a wrong bit in the captured frame. Write-type and read-type frames are told apart by the captured turnaround, by any overlap between the block's drive and the responder's drive, and by whether the low half of the word changes at frame end. A field-only write before each launch and a write injected in the middle of some frames separate a correct start condition and busy lockout from a block that reacts to every write.

// File: rtl/mdio_cmd_pkg.sv
package mdio_cmd_pkg;

   localparam int CMD_W   = 32;
   localparam int DATA_W  = 16;
   localparam int ADDR_W  = 5;
   localparam int GO_POS  = 31;

   // Field order follows the command word from bit 29 down to bit 0
   typedef struct packed {
      logic [ADDR_W-1:0] ra;    // register or device address
      logic [ADDR_W-1:0] phy;   // port address
      logic [1:0]        op;    // opcode
      logic [1:0]        st;    // start code
      logic [DATA_W-1:0] data;  // data / address payload
   } mdio_fields_t;

   localparam int FIELDS_W = $bits(mdio_fields_t);

   // Opcode bit 1 marks a frame whose data half comes from the responder
   function automatic logic op_is_read(input logic [1:0] op);
      return op[1];
   endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
   parameter int DIV_HALF = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic mdc,
   output logic rise_stb,
   output logic fall_stb
);

   logic tick;

   generate
      if (DIV_HALF < 1) begin : g_bad_div
         $error("mdio_mdc_gen: DIV_HALF must be at least 1");
      end

      if (DIV_HALF == 1) begin : g_div_direct
         assign tick = run;
      end else begin : g_div_count
         localparam int CW = $clog2(DIV_HALF);
         logic [CW-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt <= '0;
            else if (!run || tick)
               cnt <= '0;
            else
               cnt <= cnt + 1'b1;
         end

         assign tick = run && (cnt == CW'(DIV_HALF - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mdc <= 1'b0;
      else if (!run)
         mdc <= 1'b0;
      else if (tick)
         mdc <= ~mdc;
   end

   assign rise_stb = tick && !mdc;
   assign fall_stb = tick && mdc;

   // R4: clock held low whenever no frame runs
   p_mdc_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !mdc);

endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
   import mdio_cmd_pkg::*;
#(
   parameter int PRE_LEN = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  mdio_fields_t        fields,
   input  logic                rise_stb,
   input  logic                fall_stb,
   input  logic                mdio_i,
   output logic                run,
   output logic                mdio_o,
   output logic                mdio_oe,
   output logic                done,
   output logic                done_rd,
   output logic [DATA_W-1:0]   rd_data
);

   localparam int FLEN    = PRE_LEN + 32;
   localparam int IW      = $clog2(FLEN);
   localparam int TA_IDX  = PRE_LEN + 14;
   localparam int DAT_IDX = PRE_LEN + 16;

   generate
      if (PRE_LEN < 1) begin : g_bad_pre
         $error("mdio_frame_eng: PRE_LEN must be at least 1");
      end
   endgenerate

   logic [FLEN-1:0] sh;
   logic [IW-1:0]   idx;
   logic            is_rd;
   logic [1:0]      ta_bits;

   assign ta_bits = op_is_read(fields.op) ? 2'b11 : 2'b10;
   assign done    = run && fall_stb && (idx == IW'(FLEN - 1));
   assign done_rd = done && is_rd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh      <= '0;
         idx     <= '0;
         is_rd   <= 1'b0;
         run     <= 1'b0;
         rd_data <= '0;
      end else if (start && !run) begin
         sh    <= {{PRE_LEN{1'b1}}, fields.st, fields.op, fields.phy,
                   fields.ra, ta_bits, fields.data};
         idx   <= '0;
         is_rd <= op_is_read(fields.op);
         run   <= 1'b1;
      end else if (run) begin
         if (rise_stb && is_rd && (idx >= IW'(DAT_IDX)))
            rd_data <= {rd_data[DATA_W-2:0], mdio_i};
         if (fall_stb) begin
            sh  <= {sh[FLEN-2:0], 1'b0};
            idx <= idx + 1'b1;
            if (done)
               run <= 1'b0;
         end
      end
   end

   assign mdio_o  = sh[FLEN-1];
   assign mdio_oe = run && !(is_rd && (idx >= IW'(TA_IDX)));

   // R5: the driven value moves only on a falling clock edge
   p_mdo_fall_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !fall_stb) |=> $stable(mdio_o));

   // R6: a read lets go of the line once the first turnaround bit begins
   p_release_ta_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (run && is_rd && fall_stb && (idx == IW'(TA_IDX - 1))) |=> !mdio_oe);

endmodule

// File: rtl/mdio_cmd_ctrl.sv
module mdio_cmd_ctrl
   import mdio_cmd_pkg::*;
#(
   parameter int DIV_HALF = 4,
   parameter int PRE_LEN  = 32
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr_en,
   input  logic [31:0] reg_wr_data,
   output logic [31:0] reg_rd_data,
   output logic        mdc,
   output logic        mdio_o,
   output logic        mdio_oe,
   input  logic        mdio_i
);

   mdio_fields_t      fld;
   mdio_fields_t      wr_fld;
   logic              busy;
   logic              go;
   logic              run;
   logic              rise_stb;
   logic              fall_stb;
   logic              eng_done;
   logic              eng_done_rd;
   logic [DATA_W-1:0] eng_rd_data;
   logic              unused_bit30;

   assign unused_bit30 = reg_wr_data[30];
   assign wr_fld       = mdio_fields_t'(reg_wr_data[FIELDS_W-1:0]);
   assign go           = reg_wr_en && !busy && reg_wr_data[GO_POS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fld  <= '0;
         busy <= 1'b0;
      end else if (reg_wr_en && !busy) begin
         fld  <= wr_fld;
         busy <= reg_wr_data[GO_POS];
      end else if (eng_done) begin
         busy <= 1'b0;
         if (eng_done_rd)
            fld.data <= eng_rd_data;
      end
   end

   assign reg_rd_data = {busy, 1'b0, fld};

   mdio_mdc_gen #(.DIV_HALF(DIV_HALF)) u_mdc (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .mdc      (mdc),
      .rise_stb (rise_stb),
      .fall_stb (fall_stb)
   );

   mdio_frame_eng #(.PRE_LEN(PRE_LEN)) u_eng (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (go),
      .fields   (wr_fld),
      .rise_stb (rise_stb),
      .fall_stb (fall_stb),
      .mdio_i   (mdio_i),
      .run      (run),
      .mdio_o   (mdio_o),
      .mdio_oe  (mdio_oe),
      .done     (eng_done),
      .done_rd  (eng_done_rd),
      .rd_data  (eng_rd_data)
   );

   // R3: a field write with the go bit low leaves the block idle
   p_start_only_go_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_en && !busy && !reg_wr_data[GO_POS]) |=> !busy);

   // R2: busy holds until the engine reports the end of the frame
   p_busy_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !eng_done) |=> busy);

   // R8: fields cannot change in the middle of a frame
   p_ignore_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !eng_done) |=> $stable(reg_rd_data[29:0]));

   // R9: idle means line released and clock low
   p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mdio_oe && !mdc));

endmodule

// File: tb/sim_mdio_cmd_ctrl.sv
module sim_mdio_cmd_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int DIV        = 2;
   localparam int PRE        = 32;
   localparam int FBITS      = PRE + 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic [31:0] reg_wr_data = '0;
   logic [31:0] reg_rd_data;
   logic        mdc, mdio_o, mdio_oe;
   logic        phy_en = 1'b0;
   logic        phy_val = 1'b1;
   logic        mdio_line;

   int          n_chk = 0;
   int          n_bad = 0;

   assign mdio_line = mdio_oe ? mdio_o : (phy_en ? phy_val : 1'b1);

   always #(CLK_PERIOD/2) clk = ~clk;

   mdio_cmd_ctrl #(.DIV_HALF(DIV), .PRE_LEN(PRE)) u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .reg_wr_en   (reg_wr_en),
      .reg_wr_data (reg_wr_data),
      .reg_rd_data (reg_rd_data),
      .mdc         (mdc),
      .mdio_o      (mdio_o),
      .mdio_oe     (mdio_oe),
      .mdio_i      (mdio_line)
   );

   // Simple responder: records every bit at rising MDC, answers reads
   int          rc = 0;
   logic [63:0] cap = '0;
   logic [15:0] resp = '0;
   logic        clash = 1'b0;

   always @(posedge mdc) begin
      if (mdio_oe && phy_en) clash = 1'b1;
      if (rc < FBITS) cap[FBITS-1-rc] = mdio_line;
      rc = rc + 1;
   end

   always @(negedge mdc) begin
      if (rc >= PRE + 15 && rc < FBITS && cap[FBITS-1-(PRE+2)]) begin
         phy_en  = 1'b1;
         phy_val = (rc == PRE + 15) ? 1'b0 : resp[15-(rc-(PRE+16))];
      end else begin
         phy_en = 1'b0;
      end
   end

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic write_reg(input logic [31:0] w);
      @(negedge clk);
      reg_wr_en   = 1'b1;
      reg_wr_data = w;
      @(negedge clk);
      reg_wr_en   = 1'b0;
   endtask

   task automatic run_frame(input logic [1:0] st, input logic [1:0] op,
                            input logic [4:0] phy, input logic [4:0] ra,
                            input logic [15:0] data, input bit inject,
                            input string tag);
      logic [31:0] word;
      logic [63:0] expf;
      logic [15:0] expd;
      int          bcnt;
      word = {2'b00, ra, phy, op, st, data};
      resp = {ra, phy, ~ra, 1'b1};
      expd = op[1] ? resp : data;
      expf = {{PRE{1'b1}}, st, op, phy, ra, 2'b10, expd};
      rc = 0;
      clash = 1'b0;
      cap = '0;

      write_reg(word);
      repeat (5) @(negedge clk);
      chk("R3", "busy after field write", 64'(reg_rd_data[31]), 64'd0);
      chk("R3", "mdc edges after field write", 64'(rc), 64'd0);
      chk("R1", "field readback", 64'(reg_rd_data), 64'(word));

      write_reg(word | 32'h8000_0000);
      bcnt = 0;
      while (reg_rd_data[31] && bcnt < 5000) begin
         bcnt++;
         if (inject && bcnt == 50) begin
            reg_wr_en   = 1'b1;
            reg_wr_data = ~word;
         end else begin
            reg_wr_en = 1'b0;
         end
         @(negedge clk);
      end
      reg_wr_en = 1'b0;
      repeat (3) @(negedge clk);

      chk("R2", "busy length", 64'(bcnt), 64'(2 * FBITS * DIV));
      chk("R4", "rising mdc count", 64'(rc), 64'(FBITS));
      chk("R4", "mdc idle low", 64'(mdc), 64'd0);
      chk(tag, "frame bits", cap, expf);
      chk("R9", "line released after frame", 64'(mdio_oe), 64'd0);
      if (op[1]) begin
         chk("R6", "read data in low half", 64'(reg_rd_data[15:0]), 64'(resp));
         chk("R6", "no drive overlap", 64'(clash), 64'd0);
      end else begin
         chk(tag, "data field kept", 64'(reg_rd_data[15:0]), 64'(data));
      end
      chk(inject ? "R8" : "R1", "upper fields after frame",
          64'(reg_rd_data[31:16]), 64'({2'b00, ra, phy, op, st}));
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_chk++;
      n_bad++;
      $display("FAIL R2 watchdog expired: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [1:0] sts [5];
      logic [1:0] ops [5];
      string      tags [5];
      logic [4:0] addrs [3];
      sts[0] = 2'b01; ops[0] = 2'b01; tags[0] = "R5";
      sts[1] = 2'b01; ops[1] = 2'b10; tags[1] = "R6";
      sts[2] = 2'b00; ops[2] = 2'b00; tags[2] = "R7";
      sts[3] = 2'b00; ops[3] = 2'b01; tags[3] = "R5";
      sts[4] = 2'b00; ops[4] = 2'b11; tags[4] = "R6";
      addrs[0] = 5'h00; addrs[1] = 5'h15; addrs[2] = 5'h1F;

      repeat (3) @(negedge clk);
      chk("R9", "reset word", 64'(reg_rd_data), 64'd0);
      chk("R9", "reset mdc", 64'(mdc), 64'd0);
      chk("R9", "reset line drive", 64'(mdio_oe), 64'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      for (int k = 0; k < 5; k++) begin
         for (int p = 0; p < 3; p++) begin
            for (int r = 0; r < 3; r++) begin
               run_frame(sts[k], ops[k], addrs[p], addrs[2-r],
                         {addrs[p], addrs[2-r], 6'(k)} ^ 16'hA5C3,
                         (p == 1) && (r != 1), tags[k]);
            end
         end
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule